// File: doc/BRIEF.md
# Two-Channel LED Blink Controller

This block drives a small set of indicator LEDs (two by default) from per-channel 8-bit control registers. The low two bits of each register pick one of four behaviours: dark, steadily lit, a fast symmetric blink, or a slow blink with a short flash. Every pattern is built from half-second time slots. A prescaler counts system clocks to mark the slot boundaries, and a two-bit slot counter is shared by all channels, so LEDs that use the same mode flash in step.

Software reaches the registers through a plain synchronous bus. A write takes one cycle, and a read returns its data one cycle after the request together with a valid strobe. A new mode affects the LED only at the next slot boundary, so the output never carries a pulse shorter than a full slot. The prescaler length is a parameter. By default it equals half the clock frequency in hertz, and a bench can shrink it to a few cycles.

Top module: `led_blink_ctrl`

## Requirements
- R1: Mode 2'b00 in bits [1:0] of a channel's register drives that LED low in every slot.
- R2: Mode 2'b01 lights the LED in slots 0 and 2 and darkens it in slots 1 and 3, giving one slot on and one slot off (1:1).
- R3: Mode 2'b10 lights the LED only in slot 0 and darkens it in slots 1, 2 and 3, giving one slot on and three slots off (1:3).
- R4: Mode 2'b11 drives the LED high in every slot.
- R5: Bits [7:2] of every control register read as zero, and data written to them has no effect on readback or on the LED.
- R6: While reset is high and after it is released, both registers hold 0x00 and both LEDs are low. The slot counter starts at 0.
- R7: A slot boundary (tick) falls every TICK_CYCLES clocks. The first tick is on the TICK_CYCLES-th rising edge after reset is released. Each tick advances the slot counter by one, modulo 4.
- R8: LED outputs change only on the edge of a tick. On that edge each LED takes the value that its register's mode (as held before the edge) gives for the new slot. A write therefore shows from the next tick.
- R9: A read request on bus_rd returns the addressed register on bus_rdata with bus_rvalid high in the following cycle. A write on bus_wr updates the register at that edge. Address 0 selects led_o[0] and address 1 selects led_o[1].
- R10: The channels are independent. Each LED follows only its own register, and all channels share the same slot counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (1) | Register select, one register per LED |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after a read request |
| led_o | output | NUM_LEDS (2) | LED drive, high means lit |

## Verification
The assertions assume a TICK_CYCLES of at least two, so that two ticks are never back to back. They also assume that bus_wr and bus_rd are not raised in the same cycle for the same address. The stimulus writes and reads in separate cycles, always addresses a valid channel, and uses a tick period of eight clocks. The bench keeps its own slot model from the requirements and compares each LED on every cycle. Over whole four-slot windows it also counts lit cycles to confirm the 1:1 and 1:3 ratios.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned PHASE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        BLINK_OFF  = 2'b00,
        BLINK_FAST = 2'b01,
        BLINK_SLOW = 2'b10,
        BLINK_ON   = 2'b11
    } blink_mode_e;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        logic [CTRL_W-MODE_W-1:0] rsvd;
        blink_mode_e              mode;
    } ctrl_reg_t;

    // Lit or dark for a given mode in a given half-second slot
    function automatic logic slot_lit(blink_mode_e m, phase_t p);
        logic lit;
        case (m)
            BLINK_OFF:  lit = 1'b0;
            BLINK_FAST: lit = ~p[0];
            BLINK_SLOW: lit = (p == '0);
            BLINK_ON:   lit = 1'b1;
            default:    lit = 1'b0;
        endcase
        return lit;
    endfunction

    // Register image seen on the bus: reserved field forced to zero
    function automatic ctrl_reg_t pack_ctrl(blink_mode_e m);
        ctrl_reg_t r;
        r.rsvd = '0;
        r.mode = m;
        return r;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int unsigned TICK_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // R7: ticks are isolated pulses
    a_r7_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R7: prescaler never leaves its range
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/led_phase_ctr.sv
module led_phase_ctr
    import led_blink_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    output phase_t phase_o
);
    always_ff @(posedge clk) begin
        if (rst)
            phase_o <= '0;
        else if (tick_i)
            phase_o <= phase_t'(phase_o + 1'b1);
    end

    // R7: one slot per tick
    a_r7_phase_step: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> phase_o == phase_t'($past(phase_o) + 1'b1));

    a_r7_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(phase_o));

endmodule

// File: rtl/led_ctrl_regs.sv
module led_ctrl_regs
    import led_blink_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 2,
    parameter int unsigned ADDR_W   = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_i,
    input  logic                         rd_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [CTRL_W-1:0]            wdata_i,
    output logic [CTRL_W-1:0]            rdata_o,
    output logic                         rvalid_o,
    output blink_mode_e [NUM_LEDS-1:0]   mode_o
);
    localparam int unsigned SLOTS = 2 ** ADDR_W;

    blink_mode_e [SLOTS-1:0] bank;

    for (genvar g = 0; g < SLOTS; g++) begin : g_reg
        if (g < NUM_LEDS) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    bank[g] <= BLINK_OFF;
                else if (wr_i && (addr_i == ADDR_W'(g)))
                    bank[g] <= blink_mode_e'(wdata_i[MODE_W-1:0]);
            end
            assign mode_o[g] = bank[g];
        end else begin : g_hole
            assign bank[g] = BLINK_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i)
                rdata_o <= pack_ctrl(bank[addr_i]);
        end
    end

    // R9: read answers one cycle later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> rvalid_o);

    // R5: reserved bits always read as zero
    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> rdata_o[CTRL_W-1:MODE_W] == '0);

endmodule

// File: rtl/led_drive.sv
module led_drive
    import led_blink_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  phase_t      phase_i,
    input  blink_mode_e mode_i,
    output logic        led_o
);
    phase_t next_phase;
    assign next_phase = phase_t'(phase_i + 1'b1);

    always_ff @(posedge clk) begin
        if (rst)
            led_o <= 1'b0;
        else if (tick_i)
            led_o <= slot_lit(mode_i, next_phase);
    end

    // R8: output only moves on a tick edge
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(led_o));

    // R1: off mode is dark
    a_r1_off_dark: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == BLINK_OFF) |=> !led_o);

    // R4: on mode is lit
    a_r4_on_lit: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == BLINK_ON) |=> led_o);

    // R3: slow blink is dark outside slot 0
    a_r3_slow_dark: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == BLINK_SLOW && phase_i != 2'd3) |=> !led_o);

    // R2: fast blink is dark in odd slots
    a_r2_fast_odd_dark: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mode_i == BLINK_FAST && !phase_i[0]) |=> !led_o);

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TICK_CYCLES = CLK_HZ / 2,
    parameter int unsigned NUM_LEDS    = 2,
    parameter int unsigned ADDR_W      = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_LEDS-1:0] led_o
);
    logic                       tick;
    phase_t                     phase;
    blink_mode_e [NUM_LEDS-1:0] modes;

    led_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    led_phase_ctr u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .phase_o (phase)
    );

    led_ctrl_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .rvalid_o (bus_rvalid),
        .mode_o   (modes)
    );

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        led_drive u_drive (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick),
            .phase_i (phase),
            .mode_i  (modes[g]),
            .led_o   (led_o[g])
        );
    end

    // R6: outputs dark in the cycle after reset
    a_r6_reset_dark: assert property (@(posedge clk)
        rst |=> led_o == '0);

endmodule

// File: tb/led_blink_ctrl_tb_top.sv
module led_blink_ctrl_tb_top;

    localparam int TICK = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [1:0] led_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [7:0] exp_q[$];

    // reference model state
    logic [1:0] m_mode [2];
    int         m_cnt;
    logic [1:0] m_phase;
    logic [1:0] m_led;

    always #10 clk = ~clk;

    led_blink_ctrl #(.TICK_CYCLES(TICK)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .led_o      (led_o)
    );

    function automatic logic model_lit(logic [1:0] m, logic [1:0] s);
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return (s == 2'd0) || (s == 2'd2);
            2'b10:   return (s == 2'd0);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model of the slot timing, from R6..R8
    always @(posedge clk) begin
        if (rst) begin
            m_mode[0] = 2'b00; m_mode[1] = 2'b00;
            m_cnt = 0; m_phase = 2'd0; m_led = 2'b00;
        end else begin
            if (m_cnt == TICK - 1) begin
                m_cnt = 0;
                m_phase = m_phase + 2'd1;
                for (int i = 0; i < 2; i++) m_led[i] = model_lit(m_mode[i], m_phase);
            end else begin
                m_cnt++;
            end
            if (bus_wr) m_mode[bus_addr] = bus_wdata[1:0];
        end
    end

    // monitor: LED compare every cycle, read scoreboard pops
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 2; i++)
                check(led_o[i] == m_led[i], "R8 led vs slot model", led_o[i], m_led[i]);
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected rvalid", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(bus_rdata == e, "R9/R5 read data", bus_rdata, e);
                end
            end
        end
    end

    // drivers: called at a negedge, return at a later negedge
    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] expv);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(expv);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic align_tick();
        do @(negedge clk); while (m_cnt != 0);
    endtask

    task automatic count_on(input int idx, input int n, output int on);
        on = led_o[idx];
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            on += led_o[idx];
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(led_o == 2'b00, "R6 leds dark in reset", led_o, 0);
        rst = 1'b0;
    endtask

    initial begin
        int on0, on1, n;
        @(negedge clk);
        do_reset();

        // R6: registers are zero after reset
        rd(1'b0, 8'h00);
        rd(1'b1, 8'h00);
        check(led_o == 2'b00, "R6 leds dark after reset", led_o, 0);

        // R7: first tick on TICK-th edge after release
        do_reset();
        wr(1'b0, 8'h03);
        n = 1;
        while (!led_o[0] && n < 4 * TICK) begin
            @(negedge clk);
            n++;
        end
        check(n == TICK, "R7 first tick position", n, TICK);

        // R2, R3, R10: fast on LED0, slow on LED1
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h02);
        align_tick(); align_tick();
        count_on(0, 4 * TICK, on0);
        // window continues with LED1 on an aligned fresh window
        check(on0 == 2 * TICK, "R2 fast blink 1:1 ratio", on0, 2 * TICK);
        align_tick();
        count_on(1, 4 * TICK, on1);
        check(on1 == TICK, "R3 slow blink 1:3 ratio", on1, TICK);
        rd(1'b0, 8'h01);
        rd(1'b1, 8'h02);
        check(1'b1, "R10 channels independent (model compare)", 0, 0);

        // R4, R1, R5: all-ones write keeps only the mode field
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'hFC);
        rd(1'b0, 8'h03);
        rd(1'b1, 8'h00);
        align_tick(); align_tick();
        count_on(0, 4 * TICK, on0);
        check(on0 == 4 * TICK, "R4 steady on", on0, 4 * TICK);
        align_tick();
        count_on(1, 4 * TICK, on1);
        check(on1 == 0, "R1 steady off", on1, 0);

        // R5: reserved bits ignored, LED1 still blinks fast
        wr(1'b1, 8'hFD);
        rd(1'b1, 8'h01);
        align_tick(); align_tick();
        count_on(1, 4 * TICK, on1);
        check(on1 == 2 * TICK, "R5 reserved write ignored", on1, 2 * TICK);

        // R8: mid-slot mode change waits for the next tick
        align_tick();
        check(led_o[0] == 1'b1, "R8 led0 lit before change", led_o[0], 1);
        wr(1'b0, 8'h00);
        repeat (2) @(negedge clk);
        check(led_o[0] == 1'b1, "R8 change held until tick", led_o[0], 1);
        align_tick();
        check(led_o[0] == 1'b0, "R8 change applied at tick", led_o[0], 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule